// File: doc/BRIEF.md
# Conditional branch and skip resolver

This block works out the next program-counter value for a small processor core whenever the current instruction is a conditional relative branch or a conditional skip. Each cycle the sequencer presents the current PC, an operation code, a 7-bit signed relative offset, the 8-bit status byte, the byte being tested together with a 3-bit bit index, an equality flag from the register comparator, and a flag saying whether the instruction after the current one is two words long.

One clock edge later the block presents the resolved next PC, whether the branch or skip was taken, and the number of cycles the sequencer has to spend on the instruction. The outputs are registered and the block holds no other state. A plain relative jump can also be sent through the block, which then computes its target and always reports it as taken.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_n` is low, every clock edge clears `npc_o`, `taken_o` and `cyc_o` to zero. Otherwise each clock edge loads the outputs from the inputs present at that edge, so the result appears one cycle after the inputs.
- R2: For a taken branch (operation codes 0 to 12), `npc_o` equals `pc_i` plus the sign-extended `off_i` plus one, modulo 2^PC_W, and `cyc_o` is 2.
- R3: For a branch or skip that is not taken, `npc_o` equals `pc_i` plus one, modulo 2^PC_W, `taken_o` is 0 and `cyc_o` is 1.
- R4: Codes 1 (bit set) and 2 (bit clear) test `sreg_i[sel_i]`. The status bit positions are: 0 carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half-carry, 6 transfer, 7 interrupt enable.
- R5: Code 3 is taken when the zero bit is 1 and code 4 when it is 0. Code 7 is taken when the negative bit is 1 and code 8 when it is 0.
- R6: Code 5 (lower) is taken when the carry bit is 1. Code 6 (same or higher) is taken when the carry bit is 0.
- R7: Code 9 (signed greater or equal) is taken when negative XOR overflow is 0. Code 10 (signed less than) is taken when it is 1.
- R8: Code 11 is taken when the half-carry bit is 1. Code 12 is taken when it is 0.
- R9: Code 13 (skip if equal) is taken when `eq_i` is 1.
- R10: Code 14 skips when `tbyte_i[sel_i]` is 0. Code 15 skips when it is 1.
- R11: A taken skip (codes 13 to 15) sets `npc_o` to `pc_i` plus 2 with `cyc_o` 2 when `next_long_i` is 0. When `next_long_i` is 1 it sets `npc_o` to `pc_i` plus 3 with `cyc_o` 3. Both results wrap modulo 2^PC_W.
- R12: Code 0 passes a relative jump through. It is always taken, and its target and cost follow R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code (0 to 15) |
| pc_i | input | PC_W | Current program counter |
| off_i | input | OFF_W | Signed relative offset |
| sreg_i | input | 8 | Status byte |
| tbyte_i | input | 8 | Register or I/O byte tested by a bit skip |
| sel_i | input | 3 | Bit index for status or tested byte |
| eq_i | input | 1 | The two compared registers are equal |
| next_long_i | input | 1 | The following instruction is two words long |
| npc_o | output | PC_W | Resolved next program counter |
| taken_o | output | 1 | Branch or skip taken |
| cyc_o | output | 2 | Cycles the instruction costs |

## Verification
Every cycle the assertions check the link between the three outputs and the previous cycle's PC, offset and next-instruction length. They cover the fall-through target and cost, the taken-branch target with sign extension and wraparound, the 2-word and 3-word skip advances, the signed greater-or-equal condition, and the clearing during reset. Only the bench's scenarios show that each operation code picks the right status bit, tested-byte bit or equality input. The same holds for the index mapping of the generic bit forms and for the wrap at the ends of the address space under directed and pseudo-random input patterns.

// File: rtl/branch_skip_unit.sv
module branch_skip_unit #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       sreg_i,
  input  logic [7:0]       tbyte_i,
  input  logic [2:0]       sel_i,
  input  logic             eq_i,
  input  logic             next_long_i,
  output logic [PC_W-1:0]  npc_o,
  output logic             taken_o,
  output logic [1:0]       cyc_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic fc, fz, fn, fv, fh;
  assign fc = sreg_i[0];
  assign fz = sreg_i[1];
  assign fn = sreg_i[2];
  assign fv = sreg_i[3];
  assign fh = sreg_i[5];

  logic hit;
  always_comb begin
    case (op_i)
      4'd0:    hit = 1'b1;
      4'd1:    hit = sreg_i[sel_i];
      4'd2:    hit = ~sreg_i[sel_i];
      4'd3:    hit = fz;
      4'd4:    hit = ~fz;
      4'd5:    hit = fc;
      4'd6:    hit = ~fc;
      4'd7:    hit = fn;
      4'd8:    hit = ~fn;
      4'd9:    hit = ~(fn ^ fv);
      4'd10:   hit = fn ^ fv;
      4'd11:   hit = fh;
      4'd12:   hit = ~fh;
      4'd13:   hit = eq_i;
      4'd14:   hit = ~tbyte_i[sel_i];
      default: hit = tbyte_i[sel_i];
    endcase
  end

  logic            is_skip;
  logic [PC_W-1:0] off_ext, br_tgt, sk_tgt, nxt;
  logic [1:0]      cost;

  assign is_skip = op_i >= 4'd13;
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign br_tgt  = pc_i + off_ext + PC_W'(1);
  assign sk_tgt  = pc_i + (next_long_i ? PC_W'(3) : PC_W'(2));

  always_comb begin
    if (!hit) begin
      nxt  = pc_i + PC_W'(1);
      cost = 2'd1;
    end else if (is_skip) begin
      nxt  = sk_tgt;
      cost = next_long_i ? 2'd3 : 2'd2;
    end else begin
      nxt  = br_tgt;
      cost = 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_o   <= '0;
      taken_o <= 1'b0;
      cyc_o   <= 2'd0;
    end else begin
      npc_o   <= nxt;
      taken_o <= hit;
      cyc_o   <= cost;
    end
  end
endmodule

// File: rtl/branch_skip_unit_chk.sv
module branch_skip_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [OFF_W-1:0] off_i,
  input logic [7:0]       sreg_i,
  input logic [7:0]       tbyte_i,
  input logic [2:0]       sel_i,
  input logic             eq_i,
  input logic             next_long_i,
  input logic [PC_W-1:0]  npc_o,
  input logic             taken_o,
  input logic [1:0]       cyc_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= rst_n;

  logic [PC_W-1:0] sx;
  assign sx = PC_W'($signed(off_i));

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (npc_o == '0 && !taken_o && cyc_o == 2'd0));

  a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !taken_o) |-> (cyc_o == 2'd1 && npc_o == $past(pc_i) + PC_W'(1)));

  a_r2_taken_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o && $past(op_i) < 4'd13) |->
      (cyc_o == 2'd2 && npc_o == $past(pc_i) + $past(sx) + PC_W'(1)));

  a_r11_skip_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o && $past(op_i) >= 4'd13) |->
      (npc_o == $past(pc_i) + ($past(next_long_i) ? PC_W'(3) : PC_W'(2)) &&
       cyc_o == ($past(next_long_i) ? 2'd3 : 2'd2)));

  a_r7_signed_ge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 4'd9) |-> (taken_o == !($past(sreg_i[2]) ^ $past(sreg_i[3]))));

  a_r12_pass_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(op_i) == 4'd0) |-> taken_o);
endmodule

bind branch_skip_unit branch_skip_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] pc_i = '0;
  logic [6:0]  off_i = '0;
  logic [7:0]  sreg_i = '0;
  logic [7:0]  tbyte_i = '0;
  logic [2:0]  sel_i = '0;
  logic        eq_i = 1'b0;
  logic        next_long_i = 1'b0;
  logic [15:0] npc_o;
  logic        taken_o;
  logic [1:0]  cyc_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_skip_unit u_branch_skip_unit (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (op=%0d pc=%0d)", req, act, exp, op_i, pc_i);
    end
  endtask

  function automatic bit model_hit(input int op, input bit [7:0] sr, input bit [7:0] tb,
                                   input int sel, input bit eq);
    case (op)
      0: return 1;
      1: return sr[sel];
      2: return !sr[sel];
      3: return sr[1];
      4: return !sr[1];
      5: return sr[0];
      6: return !sr[0];
      7: return sr[2];
      8: return !sr[2];
      9: return sr[2] == sr[3];
      10: return sr[2] != sr[3];
      11: return sr[5];
      12: return !sr[5];
      13: return eq;
      14: return !tb[sel];
      default: return tb[sel];
    endcase
  endfunction

  function automatic string cond_tag(input int op);
    if (op == 0) return "R12";
    if (op <= 2) return "R4";
    if (op == 5 || op == 6) return "R6";
    if (op == 9 || op == 10) return "R7";
    if (op == 11 || op == 12) return "R8";
    if (op <= 8) return "R5";
    if (op == 13) return "R9";
    return "R10";
  endfunction

  task automatic step(input int op, input int pc, input int off, input int sr,
                      input int tb, input int sel, input bit eq, input bit lng);
    bit h;
    int soff, exp_pc, exp_cyc;
    string tg;
    op_i = 4'(op); pc_i = 16'(pc); off_i = 7'(off); sreg_i = 8'(sr);
    tbyte_i = 8'(tb); sel_i = 3'(sel); eq_i = eq; next_long_i = lng;
    h = model_hit(op, 8'(sr), 8'(tb), sel, eq);
    soff = (off & 127) >= 64 ? (off & 127) - 128 : (off & 127);
    if (!h) begin exp_pc = pc + 1; exp_cyc = 1; tg = "R3"; end
    else if (op >= 13) begin exp_pc = pc + (lng ? 3 : 2); exp_cyc = lng ? 3 : 2; tg = "R11"; end
    else begin exp_pc = pc + soff + 1; exp_cyc = 2; tg = "R2"; end
    exp_pc = ((exp_pc % 65536) + 65536) % 65536;
    @(posedge clk);
    @(negedge clk);
    check(cond_tag(op), int'(taken_o), int'(h));
    check(tg, int'(npc_o), exp_pc);
    check(tg, int'(cyc_o), exp_cyc);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_i = 4'd9; pc_i = 16'h1234; sreg_i = 8'hFF; eq_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(npc_o), 0);
    check("R1", int'(taken_o), 0);
    check("R1", int'(cyc_o), 0);
    rst_n = 1'b1;

    // R2 / R12: forward, backward and wrapping relative targets
    step(0, 100, 5, 0, 0, 0, 0, 0);
    step(0, 100, 7'h40, 0, 0, 0, 0, 0);
    step(0, 16'h0010, 7'h40, 0, 0, 0, 0, 0);
    step(0, 16'hFFFF, 7'h3F, 0, 0, 0, 0, 0);
    // R3: not-taken wraps from the top
    step(3, 16'hFFFF, 3, 8'h00, 0, 0, 0, 0);
    // R4: every status index, set and clear forms
    for (int s = 0; s < 8; s++) begin
      step(1, 200, 2, 8'(1 << s), 0, s, 0, 0);
      step(2, 200, 2, 8'(1 << s), 0, s, 0, 0);
      step(1, 200, 2, 8'(~(1 << s)), 0, s, 0, 0);
    end
    // R5..R8: named conditions on all flag combinations of C,Z,N,V,H
    for (int op = 3; op <= 12; op++)
      for (int v = 0; v < 32; v++)
        step(op, 300 + v, 7'h7E, {2'b00, v[4], 1'b0, v[3], v[2], v[1], v[0]}, 0, 0, 0, 0);
    // R9 / R11: skip-equal with both next-instruction lengths, wrap at top
    step(13, 500, 0, 0, 0, 0, 1, 0);
    step(13, 500, 0, 0, 0, 0, 1, 1);
    step(13, 500, 0, 0, 0, 0, 0, 1);
    step(13, 16'hFFFE, 0, 0, 0, 0, 1, 1);
    // R10: every tested bit, both polarities
    for (int b = 0; b < 8; b++) begin
      step(14, 600, 0, 0, 8'(1 << b), b, 0, b[0]);
      step(15, 600, 0, 0, 8'(1 << b), b, 0, b[0]);
      step(14, 600, 0, 0, 8'(~(1 << b)), b, 0, 1);
    end
    // mixed pseudo-random patterns over all codes
    for (int n = 0; n < 3000; n++)
      step($urandom_range(15), $urandom_range(65535), $urandom_range(127), $urandom_range(255),
           $urandom_range(255), $urandom_range(7), 1'($urandom_range(1)), 1'($urandom_range(1)));
    // R1 again mid-run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", int'(cyc_o), 0);
    check("R1", int'(taken_o), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule